// File: doc/BRIEF.md
# JTAG Test Access Port with Breakpoint Address Register

This block is the target-side end of a boundary-scan debug chain. A host drives the test clock, the mode-select line and serial data in, and reads serial data out. A sixteen-state controller follows the mode-select line on every rising test-clock edge. A 4-bit instruction register chooses which data register sits between the serial input and the serial output. Three data registers are available: a single-stage pass-through stage, a 32-bit identification word and a 32-bit breakpoint-address register.

When the host completes a data scan while the breakpoint instruction is selected, the block presents the new 32-bit address to the processor side. It also raises a valid strobe for exactly one test-clock cycle. The address then holds until the next such update or until reset. Serial data moves least significant bit first. The output line changes only on falling edges and is enabled only while a register is being shifted.

Top module: `jtag_bkpt_tap`

## Requirements
- R1: From any controller state, five consecutive rising TCK edges with TMS high reach Test-Logic-Reset. The observable effects are that the TDO enable is low and the next data scan returns the identification word.
- R2: Test-Logic-Reset selects the identification instruction, code 4'b0001.
- R3: The instruction register is 4 bits wide. Capture-IR loads 4'b0101, which is shifted out on TDO least significant bit first, so the first two bits seen are 1 then 0.
- R4: Instruction code 4'b0010 selects the 32-bit breakpoint-address register. Capture-DR loads it with the address currently driven on the breakpoint output, and it is shifted LSB first.
- R5: The breakpoint address output changes only on the rising edge that leaves Update-DR with code 4'b0010 active. Shifting and the Exit states leave it unchanged. After the update it equals the 32 bits shifted in.
- R6: The breakpoint valid strobe is high for exactly one TCK cycle, in the cycle after Update-DR, and only when code 4'b0010 is active.
- R7: Code 4'b1111 and every code other than 4'b0001 and 4'b0010 select a one-stage bypass path. It captures 0, and TDO after each shift edge equals the TDI bit taken at that edge.
- R8: Under code 4'b0001, the shifted-out word has version in bits 31:28, part number in bits 27:12, manufacturer in bits 11:1, and bit 0 equal to 1.
- R9: TDO changes only on falling TCK edges. The TDO enable is high only in Shift-IR and Shift-DR.
- R10: An active-low TRST, asynchronously and without a clock edge, forces the following: the TDO enable low, the breakpoint address to zero, the valid strobe low, and after release the identification instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Controller mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdoEn | output | 1 | High while TDO carries shifted data |
| bkptAddr | output | 32 | Last programmed breakpoint address |
| bkptValid | output | 1 | One-cycle strobe on a breakpoint update |

## Verification
All sixteen instruction codes are loaded in turn, each followed by a 32-bit data scan of a distinct pattern. This tells the identification path, the breakpoint readback of the previous address, and the one-bit delay of the bypass path apart. It also shows that only code 4'b0010 moves the address and fires the strobe. Pseudo-random mode-select walks of varying length, each ending in five high bits, reach many different controller states before the reset sequence. An explicit exit from Shift-DR and an asynchronous reset during a shift show that both reset routes restore the identification instruction. A check at every rising edge confirms that TDO never moves there.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  // Standard sixteen-state controller encoding
  typedef enum logic [3:0] {
    ST_RESET  = 4'hF,
    ST_IDLE   = 4'hC,
    ST_SELDR  = 4'h7,
    ST_CAPDR  = 4'h6,
    ST_SHDR   = 4'h2,
    ST_EX1DR  = 4'h1,
    ST_PAUDR  = 4'h3,
    ST_EX2DR  = 4'h0,
    ST_UPDDR  = 4'h5,
    ST_SELIR  = 4'h4,
    ST_CAPIR  = 4'hE,
    ST_SHIR   = 4'hA,
    ST_EX1IR  = 4'h9,
    ST_PAUIR  = 4'hB,
    ST_EX2IR  = 4'h8,
    ST_UPDIR  = 4'hD
  } tapState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureDr;
    logic shiftDr;
    logic updateDr;
    logic shiftIr;
    logic selIdcode;
    logic selBkpt;
  } drStrobe_t;

endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import jtag_tap_pkg::*;
#(
  parameter int IR_W = 4,
  parameter logic [IR_W-1:0] OP_IDCODE  = 4'b0001,
  parameter logic [IR_W-1:0] OP_BKPT    = 4'b0010,
  parameter logic [IR_W-1:0] IR_CAPTURE = 4'b0101
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic            tms,
  input  logic            tdi,
  output tapState_e       tapState,
  output logic [IR_W-1:0] irReg,
  output logic            irSerial,
  output drStrobe_t       strobe
);

  tapState_e nextState;
  logic [IR_W-1:0] irShift;

  always_comb begin
    case (tapState)
      ST_RESET: nextState = tms ? ST_RESET : ST_IDLE;
      ST_IDLE:  nextState = tms ? ST_SELDR : ST_IDLE;
      ST_SELDR: nextState = tms ? ST_SELIR : ST_CAPDR;
      ST_CAPDR: nextState = tms ? ST_EX1DR : ST_SHDR;
      ST_SHDR:  nextState = tms ? ST_EX1DR : ST_SHDR;
      ST_EX1DR: nextState = tms ? ST_UPDDR : ST_PAUDR;
      ST_PAUDR: nextState = tms ? ST_EX2DR : ST_PAUDR;
      ST_EX2DR: nextState = tms ? ST_UPDDR : ST_SHDR;
      ST_UPDDR: nextState = tms ? ST_SELDR : ST_IDLE;
      ST_SELIR: nextState = tms ? ST_RESET : ST_CAPIR;
      ST_CAPIR: nextState = tms ? ST_EX1IR : ST_SHIR;
      ST_SHIR:  nextState = tms ? ST_EX1IR : ST_SHIR;
      ST_EX1IR: nextState = tms ? ST_UPDIR : ST_PAUIR;
      ST_PAUIR: nextState = tms ? ST_EX2IR : ST_PAUIR;
      ST_EX2IR: nextState = tms ? ST_UPDIR : ST_SHIR;
      ST_UPDIR: nextState = tms ? ST_SELDR : ST_IDLE;
      default:  nextState = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) tapState <= ST_RESET;
    else        tapState <= nextState;
  end

  // Instruction shift and hold registers
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= '0;
      irReg   <= OP_IDCODE;
    end else begin
      if (tapState == ST_CAPIR)     irShift <= IR_CAPTURE;
      else if (tapState == ST_SHIR) irShift <= {tdi, irShift[IR_W-1:1]};

      if (tapState == ST_RESET)      irReg <= OP_IDCODE;
      else if (tapState == ST_UPDIR) irReg <= irShift;
    end
  end

  assign irSerial = irShift[0];

  always_comb begin
    strobe.captureDr = (tapState == ST_CAPDR);
    strobe.shiftDr   = (tapState == ST_SHDR);
    strobe.updateDr  = (tapState == ST_UPDDR);
    strobe.shiftIr   = (tapState == ST_SHIR);
    strobe.selIdcode = (irReg == OP_IDCODE);
    strobe.selBkpt   = (irReg == OP_BKPT);
  end

endmodule

// File: rtl/tap_dpath.sv
module tap_dpath
  import jtag_tap_pkg::*;
#(
  parameter int DR_W = 32,
  parameter logic [DR_W-1:0] IDCODE_VAL = 32'h1
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic            tdi,
  input  drStrobe_t       strobe,
  input  logic            irSerial,
  output logic            tdo,
  output logic            tdoEn,
  output logic [DR_W-1:0] bkptAddr,
  output logic            bkptValid
);

  logic [DR_W-1:0] drShift;
  logic            bypassBit;
  logic            serialOut;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      drShift   <= '0;
      bypassBit <= 1'b0;
      bkptAddr  <= '0;
      bkptValid <= 1'b0;
    end else begin
      bkptValid <= strobe.updateDr & strobe.selBkpt;
      if (strobe.updateDr && strobe.selBkpt) bkptAddr <= drShift;
      if (strobe.captureDr) begin
        if (strobe.selIdcode)    drShift <= IDCODE_VAL;
        else if (strobe.selBkpt) drShift <= bkptAddr;
        bypassBit <= 1'b0;
      end else if (strobe.shiftDr) begin
        drShift   <= {tdi, drShift[DR_W-1:1]};
        bypassBit <= tdi;
      end
    end
  end

  always_comb begin
    if (strobe.shiftIr)                          serialOut = irSerial;
    else if (strobe.selIdcode || strobe.selBkpt) serialOut = drShift[0];
    else                                         serialOut = bypassBit;
  end

  // Output retimed to the falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= serialOut;
      tdoEn <= strobe.shiftIr | strobe.shiftDr;
    end
  end

endmodule

// File: rtl/jtag_bkpt_tap.sv
module jtag_bkpt_tap
  import jtag_tap_pkg::*;
#(
  parameter int IR_W = 4,
  parameter int DR_W = 32,
  parameter logic [3:0]  ID_VERSION = 4'h3,
  parameter logic [15:0] ID_PART    = 16'hA5C1,
  parameter logic [10:0] ID_MFR     = 11'h2B5,
  parameter logic [IR_W-1:0] OP_IDCODE  = 4'b0001,
  parameter logic [IR_W-1:0] OP_BKPT    = 4'b0010,
  parameter logic [IR_W-1:0] IR_CAPTURE = 4'b0101
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdoEn,
  output logic [DR_W-1:0] bkptAddr,
  output logic            bkptValid
);

  localparam logic [DR_W-1:0] IDCODE_VAL = DR_W'({ID_VERSION, ID_PART, ID_MFR, 1'b1});

  tapState_e       tapState;
  logic [IR_W-1:0] irReg;
  logic            irSerial;
  drStrobe_t       strobe;

  tap_ctrl #(
    .IR_W(IR_W), .OP_IDCODE(OP_IDCODE), .OP_BKPT(OP_BKPT), .IR_CAPTURE(IR_CAPTURE)
  ) uCtrl (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi),
    .tapState(tapState), .irReg(irReg), .irSerial(irSerial), .strobe(strobe)
  );

  tap_dpath #(
    .DR_W(DR_W), .IDCODE_VAL(IDCODE_VAL)
  ) uDpath (
    .tck(tck), .trstN(trstN), .tdi(tdi), .strobe(strobe), .irSerial(irSerial),
    .tdo(tdo), .tdoEn(tdoEn), .bkptAddr(bkptAddr), .bkptValid(bkptValid)
  );

endmodule

// File: rtl/tap_checker.sv
module tap_checker
  import jtag_tap_pkg::*;
#(
  parameter int IR_W = 4,
  parameter int DR_W = 32,
  parameter logic [IR_W-1:0] OP_IDCODE = 4'b0001,
  parameter logic [IR_W-1:0] OP_BKPT   = 4'b0010
) (
  input logic            tck,
  input logic            trstN,
  input logic            tms,
  input logic            tdoEn,
  input logic            bkptValid,
  input logic [DR_W-1:0] bkptAddr,
  input tapState_e       tapState,
  input logic [IR_W-1:0] irReg
);

  a_r1_reset_sticky: assert property (@(posedge tck) disable iff (!trstN)
    (tapState == ST_RESET && tms) |=> tapState == ST_RESET);

  a_r2_reset_selects_id: assert property (@(posedge tck) disable iff (!trstN)
    (tapState == ST_RESET) |=> irReg == OP_IDCODE);

  a_r5_addr_moves_with_strobe: assert property (@(posedge tck) disable iff (!trstN)
    !$stable(bkptAddr) |-> bkptValid);

  a_r6_strobe_one_cycle: assert property (@(posedge tck) disable iff (!trstN)
    bkptValid |=> !bkptValid);

  a_r6_strobe_cause: assert property (@(posedge tck) disable iff (!trstN)
    $rose(bkptValid) |-> ($past(tapState) == ST_UPDDR && $past(irReg) == OP_BKPT));

  a_r9_enable_only_shift: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> (tapState == ST_SHDR || tapState == ST_SHIR));

endmodule

bind jtag_bkpt_tap tap_checker #(
  .IR_W(IR_W), .DR_W(DR_W), .OP_IDCODE(OP_IDCODE), .OP_BKPT(OP_BKPT)
) uChk (
  .tck(tck), .trstN(trstN), .tms(tms), .tdoEn(tdoEn), .bkptValid(bkptValid),
  .bkptAddr(bkptAddr), .tapState(tapState), .irReg(irReg)
);

// File: tb/tb_jtag_bkpt_tap.sv
module tb_jtag_bkpt_tap;

  localparam logic [3:0]  VER  = 4'h3;
  localparam logic [15:0] PART = 16'hA5C1;
  localparam logic [10:0] MFR  = 11'h2B5;
  localparam logic [31:0] EXP_ID = {VER, PART, MFR, 1'b1};
  localparam logic [3:0]  C_ID = 4'b0001;
  localparam logic [3:0]  C_BK = 4'b0010;

  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdoEn, bkptValid;
  logic [31:0] bkptAddr;

  int errCnt = 0;
  int chkCnt = 0;

  logic [31:0] model;
  logic [31:0] dout;
  logic [3:0]  cap;
  logic held, pulse, cleared;
  logic [15:0] lf;

  always #10 tck = ~tck;

  jtag_bkpt_tap #(
    .ID_VERSION(VER), .ID_PART(PART), .ID_MFR(MFR)
  ) dut (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdoEn(tdoEn), .bkptAddr(bkptAddr), .bkptValid(bkptValid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  endtask

  // One TCK cycle; TDO must not move at the rising edge (R9)
  task automatic tick(input logic m, input logic d);
    logic pre;
    tms = m;
    tdi = d;
    pre = tdo;
    @(posedge tck);
    #1;
    check(tdo === pre, "R9 tdo moved at rising edge", {31'b0, tdo}, {31'b0, pre});
    @(negedge tck);
    #1;
  endtask

  task automatic scanIr(input logic [3:0] v, output logic [3:0] c);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    check(tdoEn === 1'b1, "R9 enable in Shift-IR", {31'b0, tdoEn}, 32'd1);
    for (int i = 0; i < 4; i++) begin
      c[i] = tdo;
      tick(i == 3, v[i]);
    end
    tick(1, 0); tick(0, 0);
    check(tdoEn === 1'b0, "R9 enable low in idle", {31'b0, tdoEn}, 32'd0);
  endtask

  task automatic scanDr(input logic [31:0] din, output logic [31:0] q,
                        output logic addrHeld, output logic pls, output logic clr);
    logic [31:0] a0;
    a0 = bkptAddr;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 32; i++) begin
      q[i] = tdo;
      if (bkptAddr !== a0) a0 = 32'hxxxx_xxxx;
      tick(i == 31, din[i]);
    end
    addrHeld = (bkptAddr === a0) && (bkptValid === 1'b0);
    tick(1, 0);
    addrHeld = addrHeld && (bkptValid === 1'b0);
    tick(0, 0);
    pls = bkptValid;
    tick(0, 0);
    clr = !bkptValid;
  endtask

  initial begin
    repeat (50000) @(posedge tck);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    model = 32'h0;
    repeat (3) @(negedge tck);
    #1;
    // R10: reset state at the ports
    check(tdoEn === 1'b0, "R10 tdoEn under trst", {31'b0, tdoEn}, 32'd0);
    check(bkptAddr === 32'h0, "R10 address under trst", bkptAddr, 32'h0);
    check(bkptValid === 1'b0, "R10 valid under trst", {31'b0, bkptValid}, 32'd0);
    trstN = 1'b1;
    tick(1, 0);
    tick(0, 0);

    // R2, R8: identification after reset
    scanDr(32'h1234_5678, dout, held, pulse, cleared);
    check(dout === EXP_ID, "R2 R8 idcode after reset", dout, EXP_ID);
    check(dout[0] === 1'b1, "R8 bit0", {31'b0, dout[0]}, 32'd1);
    check(dout[11:1] === MFR, "R8 manufacturer", {21'b0, dout[11:1]}, {21'b0, MFR});
    check(dout[27:12] === PART, "R8 part", {16'b0, dout[27:12]}, {16'b0, PART});
    check(dout[31:28] === VER, "R8 version", {28'b0, dout[31:28]}, {28'b0, VER});
    check(pulse === 1'b0, "R6 no strobe under idcode", {31'b0, pulse}, 32'd0);

    // R3, R4, R5, R6: breakpoint programming
    scanIr(C_BK, cap);
    check(cap === 4'b0101, "R3 capture pattern", {28'b0, cap}, 32'h5);
    scanDr(32'hCAFE_0104, dout, held, pulse, cleared);
    check(dout === 32'h0, "R4 readback of reset address", dout, 32'h0);
    check(held === 1'b1, "R5 address held during shift", {31'b0, held}, 32'd1);
    check(pulse === 1'b1, "R6 strobe after update", {31'b0, pulse}, 32'd1);
    check(cleared === 1'b1, "R6 strobe one cycle", {31'b0, cleared}, 32'd1);
    check(bkptAddr === 32'hCAFE_0104, "R5 address after update", bkptAddr, 32'hCAFE_0104);
    scanDr(32'h0BAD_F00D, dout, held, pulse, cleared);
    check(dout === 32'hCAFE_0104, "R4 readback of previous address", dout, 32'hCAFE_0104);
    check(bkptAddr === 32'h0BAD_F00D, "R5 second update", bkptAddr, 32'h0BAD_F00D);
    model = 32'h0BAD_F00D;

    // Sweep of all instruction codes (R3, R4, R6, R7, R8)
    for (int c = 0; c < 16; c++) begin
      logic [31:0] din;
      logic [31:0] exp;
      din = 32'h9E37_79B9 * (c + 1) ^ (32'h1 << c);
      scanIr(c[3:0], cap);
      check(cap === 4'b0101, "R3 capture pattern in sweep", {28'b0, cap}, 32'h5);
      scanDr(din, dout, held, pulse, cleared);
      if (c[3:0] == C_ID) begin
        exp = EXP_ID;
        check(dout === exp, "R8 idcode in sweep", dout, exp);
      end else if (c[3:0] == C_BK) begin
        exp = model;
        check(dout === exp, "R4 breakpoint readback in sweep", dout, exp);
        model = din;
      end else begin
        exp = {din[30:0], 1'b0};
        check(dout === exp, "R7 bypass delay in sweep", dout, exp);
      end
      check(pulse === (c[3:0] == C_BK), "R6 strobe only for breakpoint code", {31'b0, pulse},
            {31'b0, c[3:0] == C_BK});
      check(cleared === 1'b1, "R6 strobe width in sweep", {31'b0, cleared}, 32'd1);
      check(bkptAddr === model, "R5 address vs model", bkptAddr, model);
    end

    // R1: explicit exit from Shift-DR
    scanIr(C_BK, cap);
    tick(1, 0); tick(0, 0); tick(0, 0);
    check(tdoEn === 1'b1, "R9 enable in Shift-DR", {31'b0, tdoEn}, 32'd1);
    for (int k = 0; k < 5; k++) tick(1, 1);
    check(tdoEn === 1'b0, "R1 enable after five highs", {31'b0, tdoEn}, 32'd0);
    tick(0, 0);
    scanDr(32'h5555_AAAA, dout, held, pulse, cleared);
    check(dout === EXP_ID, "R1 idcode after TMS reset from Shift-DR", dout, EXP_ID);

    // R1: pseudo-random walks, each ending in five highs
    lf = 16'hACE1;
    for (int w = 0; w < 16; w++) begin
      scanIr(C_BK, cap);
      for (int k = 0; k < 3 + w; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        tick(lf[0], lf[1]);
      end
      for (int k = 0; k < 5; k++) tick(1, 0);
      check(tdoEn === 1'b0, "R1 enable after walk", {31'b0, tdoEn}, 32'd0);
      tick(0, 0);
      scanDr(32'h0F0F_3C3C, dout, held, pulse, cleared);
      check(dout === EXP_ID, "R1 idcode after walk", dout, EXP_ID);
    end

    // R10: asynchronous reset in the middle of a breakpoint shift
    scanIr(C_BK, cap);
    scanDr(32'h7777_1111, dout, held, pulse, cleared);
    check(bkptAddr === 32'h7777_1111, "R5 address before trst", bkptAddr, 32'h7777_1111);
    tick(1, 0); tick(0, 0); tick(0, 0); tick(0, 1);
    #3;
    trstN = 1'b0;
    #1;
    check(tdoEn === 1'b0, "R10 async enable low", {31'b0, tdoEn}, 32'd0);
    check(bkptAddr === 32'h0, "R10 async address clear", bkptAddr, 32'h0);
    check(bkptValid === 1'b0, "R10 async valid low", {31'b0, bkptValid}, 32'd0);
    tms = 1'b1;
    repeat (2) @(negedge tck);
    #1;
    trstN = 1'b1;
    tick(1, 0);
    tick(0, 0);
    scanDr(32'h2468_ACE0, dout, held, pulse, cleared);
    check(dout === EXP_ID, "R10 idcode after trst", dout, EXP_ID);
    check(bkptAddr === 32'h0, "R10 address stays clear", bkptAddr, 32'h0);

    finishRun();
  end

endmodule